// File: doc/BRIEF.md
# Dual DAC Register Bank with Power-On Load

This block keeps the digital state behind two 8-bit DAC channels. Each channel has a working (volatile) code register and a persistent (nonvolatile) copy. A shared control register, also kept in working and persistent forms, holds the soft-mute and power-down bits of both channels. A serial slave elsewhere in the chip hands the block one-cycle write strobes and a combinational read select. The block returns the selected register and drives each channel's effective code and output enable toward the analog converters.

When the soft reset `rst_n` is released, the block copies every persistent register into its working twin. It then holds both outputs muted for a timed window that is derived from the clock frequency. During that window the register file is closed to the bus. The persistent registers are modelled as flops that only the factory reset `factoryRst_n` clears, so they keep their contents across soft resets. An asynchronous mute pin, passed through two synchronizer flops, silences both channels at once. Mute and power-down only mask what reaches the outputs. The stored codes are left untouched, so whatever was written during the mode shows up when the mode ends.

Top module: `dacRegBank`

## Requirements
- R1: While `factoryRst_n` is low, all persistent registers clear to 00 hex, and after it they read 00 hex.
- R2: After `rst_n` rises, the working registers load from the persistent ones on the first clock edge. For INIT_CYCLES = CLK_HZ/1e6*INIT_US edges both channels output code 00 with enable high. After that the outputs follow the loaded data.
- R3: During the load window, write strobes have no effect on any register, and `rdData` reads 00.
- R4: A write with `wrNv`=0 to select 0 (DAC0) or 1 (DAC1) changes that channel's code after the write edge. The code is passed unchanged as offset binary. A write with `wrNv`=1 changes only the persistent copy, not the output.
- R5: Select 2 is the control register. Bit0 mutes DAC0, bit1 mutes DAC1, bit2 powers down DAC0 and bit3 powers down DAC1. Bits 7:4 are not stored and read as 0.
- R6: A soft-muted channel outputs code 00 (the low-reference code) with enable high, and its working code register keeps its value.
- R7: A powered-down channel drives its enable low and its code 00.
- R8: `muteIn` high mutes both channels whatever the control register holds. It takes effect on the second clock edge after it is seen, because of the two synchronizer flops.
- R9: Writes made while a channel is muted or powered down are stored and appear when the mode is left. Writes to the DAC registers do not alter the mode.
- R10: Persistent registers survive a soft reset. Select 3 is unused: it reads 00 and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| factoryRst_n | input | 1 | Active-low reset that clears the persistent registers |
| rst_n | input | 1 | Active-low soft reset; clears the working registers and starts the load window |
| wrEn | input | 1 | One-cycle write strobe from the serial slave |
| wrNv | input | 1 | 1 = write the persistent copy, 0 = write the working register |
| wrSel | input | 2 | Write select: 0 DAC0, 1 DAC1, 2 control, 3 unused |
| wrData | input | 8 | Write data |
| rdSel | input | 2 | Read select, same encoding as wrSel |
| rdNv | input | 1 | 1 = read the persistent copy |
| rdData | output | 8 | Combinational read data |
| muteIn | input | 1 | Asynchronous mute pin for both channels, active high |
| dacCode0 | output | 8 | Effective code for channel 0 |
| dacCode1 | output | 8 | Effective code for channel 1 |
| dacOe | output | 2 | Per-channel output enable (bit n = channel n) |

## Verification
The bench targets the edges of the load window. A design that lets a strobe through there, or shortens the window by one cycle, would show a nonzero code or a changed register too early. It checks that mute masks the output without clearing the register: a design that zeroed the stored code would come back to 00 instead of the last written value after unmute. It also checks the mute pin's two-edge latency and its priority over a clear control register. Finally it checks that persistent contents outlive a soft reset and seed the working registers, including a control value that leaves one channel muted after start-up.

// File: rtl/dacRegPkg.sv
package dacRegPkg;

  typedef enum logic [1:0] {
    SEL_DAC0 = 2'd0,
    SEL_DAC1 = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } regSel_e;

  // Strobes from the control side to the datapath
  typedef struct packed {
    logic initLoad;  // copy persistent -> working this cycle
    logic initBusy;  // load window active
    logic wrVol;     // accepted working-register write
    logic wrNv;      // accepted persistent-register write
    logic muteAll;   // synchronized mute pin
  } ctrlStrobe_t;

endpackage

// File: rtl/dacRegCtrl.sv
module dacRegCtrl
  import dacRegPkg::*;
#(
  parameter int INIT_CYCLES = 50000,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wrEn,
  input  logic        wrNv,
  input  logic        muteIn,
  output ctrlStrobe_t strb
);

  localparam int CNT_W = $clog2(INIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_START = CNT_W'(INIT_CYCLES);

  logic [CNT_W-1:0] initCnt;
  logic [SYNC_STAGES-1:0] muteSync;
  logic busy;

  assign busy = (initCnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      initCnt <= CNT_START;
    end else if (busy) begin
      initCnt <= initCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      muteSync <= '0;
    end else begin
      muteSync <= {muteSync[SYNC_STAGES-2:0], muteIn};
    end
  end

  always_comb begin
    strb.initLoad = (initCnt == CNT_START);
    strb.initBusy = busy;
    strb.wrVol    = wrEn && !wrNv && !busy;
    strb.wrNv     = wrEn &&  wrNv && !busy;
    strb.muteAll  = muteSync[SYNC_STAGES-1];
  end

endmodule

// File: rtl/dacRegData.sv
module dacRegData
  import dacRegPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CH_N   = 2
) (
  input  logic                          clk,
  input  logic                          factoryRst_n,
  input  logic                          rst_n,
  input  ctrlStrobe_t                   strb,
  input  regSel_e                       wrSel,
  input  logic [DATA_W-1:0]             wrData,
  input  regSel_e                       rdSel,
  input  logic                          rdNv,
  output logic [DATA_W-1:0]             rdData,
  output logic [CH_N-1:0][DATA_W-1:0]   code,
  output logic [CH_N-1:0]               oe
);

  localparam int CTRL_W = 2 * CH_N;

  logic [CH_N-1:0][DATA_W-1:0] nvDac;
  logic [CH_N-1:0][DATA_W-1:0] volDac;
  logic [CTRL_W-1:0]           nvCtrl;
  logic [CTRL_W-1:0]           volCtrl;

  always_ff @(posedge clk or negedge factoryRst_n) begin
    if (!factoryRst_n) begin
      nvCtrl <= '0;
    end else if (strb.wrNv && wrSel == SEL_CTRL) begin
      nvCtrl <= wrData[CTRL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      volCtrl <= '0;
    end else if (strb.initLoad) begin
      volCtrl <= nvCtrl;
    end else if (strb.wrVol && wrSel == SEL_CTRL) begin
      volCtrl <= wrData[CTRL_W-1:0];
    end
  end

  for (genvar ch = 0; ch < CH_N; ch++) begin : gChan
    logic isSel;
    logic muted;
    logic pwrDown;

    assign isSel = (wrSel == regSel_e'(ch));

    always_ff @(posedge clk or negedge factoryRst_n) begin
      if (!factoryRst_n) begin
        nvDac[ch] <= '0;
      end else if (strb.wrNv && isSel) begin
        nvDac[ch] <= wrData;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        volDac[ch] <= '0;
      end else if (strb.initLoad) begin
        volDac[ch] <= nvDac[ch];
      end else if (strb.wrVol && isSel) begin
        volDac[ch] <= wrData;
      end
    end

    assign muted   = strb.initBusy || strb.muteAll || volCtrl[ch];
    assign pwrDown = !strb.initBusy && volCtrl[CH_N + ch];
    assign code[ch] = (muted || pwrDown) ? '0 : volDac[ch];
    assign oe[ch]   = !pwrDown;
  end

  always_comb begin
    rdData = '0;
    if (!strb.initBusy) begin
      unique case (rdSel)
        SEL_DAC0: rdData = rdNv ? nvDac[0] : volDac[0];
        SEL_DAC1: rdData = rdNv ? nvDac[1] : volDac[1];
        SEL_CTRL: rdData = DATA_W'(rdNv ? nvCtrl : volCtrl);
        default:  rdData = '0;
      endcase
    end
  end

endmodule

// File: rtl/dacRegBank.sv
module dacRegBank
  import dacRegPkg::*;
#(
  parameter int CLK_HZ  = 100_000_000,
  parameter int INIT_US = 500,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              factoryRst_n,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic              wrNv,
  input  logic [1:0]        wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        rdSel,
  input  logic              rdNv,
  output logic [DATA_W-1:0] rdData,
  input  logic              muteIn,
  output logic [DATA_W-1:0] dacCode0,
  output logic [DATA_W-1:0] dacCode1,
  output logic [1:0]        dacOe
);

  localparam int CH_N        = 2;
  localparam int INIT_CYCLES = (CLK_HZ / 1_000_000) * INIT_US;

  ctrlStrobe_t strb;
  logic [CH_N-1:0][DATA_W-1:0] codeBus;

  dacRegCtrl #(
    .INIT_CYCLES (INIT_CYCLES),
    .SYNC_STAGES (2)
  ) ctrl_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wrEn   (wrEn),
    .wrNv   (wrNv),
    .muteIn (muteIn),
    .strb   (strb)
  );

  dacRegData #(
    .DATA_W (DATA_W),
    .CH_N   (CH_N)
  ) data_i (
    .clk          (clk),
    .factoryRst_n (factoryRst_n),
    .rst_n        (rst_n),
    .strb         (strb),
    .wrSel        (regSel_e'(wrSel)),
    .wrData       (wrData),
    .rdSel        (regSel_e'(rdSel)),
    .rdNv         (rdNv),
    .rdData       (rdData),
    .code         (codeBus),
    .oe           (dacOe)
  );

  assign dacCode0 = codeBus[0];
  assign dacCode1 = codeBus[1];

endmodule

// File: rtl/dacRegBankChk.sv
module dacRegBankChk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wrEn,
  input logic [DATA_W-1:0] rdData,
  input logic [DATA_W-1:0] dacCode0,
  input logic [DATA_W-1:0] dacCode1,
  input logic [1:0]        dacOe,
  input logic              initBusy,
  input logic              muteAll
);

  assert_init_muted_R2: assert property (@(posedge clk) disable iff (!rst_n)
    initBusy |-> (dacCode0 == '0 && dacCode1 == '0 && dacOe == 2'b11));

  assert_init_read_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    initBusy |-> (rdData == '0));

  assert_pd_code_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!dacOe[0] |-> dacCode0 == '0) and (!dacOe[1] |-> dacCode1 == '0));

  assert_pin_mute_R8: assert property (@(posedge clk) disable iff (!rst_n)
    muteAll |-> (dacCode0 == '0 && dacCode1 == '0));

  assert_mode_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!initBusy && !wrEn) |=> $stable(dacOe));

endmodule

bind dacRegBank dacRegBankChk #(.DATA_W(DATA_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .wrEn     (wrEn),
  .rdData   (rdData),
  .dacCode0 (dacCode0),
  .dacCode1 (dacCode1),
  .dacOe    (dacOe),
  .initBusy (strb.initBusy),
  .muteAll  (strb.muteAll)
);

// File: tb/dacRegBank_tb_top.sv
`timescale 1ns/1ps
module dacRegBank_tb_top;

  localparam int CLK_HZ  = 100_000_000;
  localparam int INIT_US = 2;
  localparam int INIT    = (CLK_HZ / 1_000_000) * INIT_US;

  logic clk = 1'b0;
  logic factoryRst_n = 1'b0;
  logic rst_n = 1'b0;
  logic wrEn = 1'b0;
  logic wrNv = 1'b0;
  logic [1:0] wrSel = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [1:0] rdSel = 2'd0;
  logic rdNv = 1'b0;
  logic [7:0] rdData;
  logic muteIn = 1'b0;
  logic [7:0] dacCode0;
  logic [7:0] dacCode1;
  logic [1:0] dacOe;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  string phase = "R1";

  always #5 clk = ~clk;

  dacRegBank #(.CLK_HZ(CLK_HZ), .INIT_US(INIT_US), .DATA_W(8)) dut_i (
    .clk(clk), .factoryRst_n(factoryRst_n), .rst_n(rst_n),
    .wrEn(wrEn), .wrNv(wrNv), .wrSel(wrSel), .wrData(wrData),
    .rdSel(rdSel), .rdNv(rdNv), .rdData(rdData), .muteIn(muteIn),
    .dacCode0(dacCode0), .dacCode1(dacCode1), .dacOe(dacOe)
  );

  // Behavioural reference model
  int mCnt;
  int mNv[3];
  int mVol[3];
  int mSync[$];

  always @(posedge clk or negedge rst_n or negedge factoryRst_n) begin
    if (!factoryRst_n) begin
      for (int i = 0; i < 3; i++) mNv[i] = 0;
    end
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) mVol[i] = 0;
      mCnt = INIT;
      mSync = '{0, 0};
    end
    if (rst_n && factoryRst_n) begin
      bit busyNow;
      busyNow = (mCnt != 0);
      mSync.push_back(int'(muteIn));
      void'(mSync.pop_front());
      if (mCnt == INIT) begin
        for (int i = 0; i < 3; i++) mVol[i] = mNv[i];
      end
      if (!busyNow && wrEn && wrSel != 2'd3) begin
        int v;
        v = (wrSel == 2'd2) ? (int'(wrData) & 15) : int'(wrData);
        if (wrNv) mNv[wrSel] = v;
        else      mVol[wrSel] = v;
      end
      if (mCnt != 0) mCnt--;
    end
  end

  function automatic int expCode(int ch);
    bit busy, mute, pd;
    busy = (mCnt != 0);
    mute = busy || (mSync[0] != 0) || mVol[2][ch];
    pd   = !busy && mVol[2][2 + ch];
    return (mute || pd) ? 0 : mVol[ch];
  endfunction

  function automatic int expOe();
    bit busy;
    busy = (mCnt != 0);
    return busy ? 3 : (3 & ~((mVol[2] >> 2) & 3));
  endfunction

  function automatic int expRd();
    if (mCnt != 0 || rdSel == 2'd3) return 0;
    return rdNv ? mNv[rdSel] : mVol[rdSel];
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(posedge clk) begin
    #3;
    if (!finished && mSync.size() == 2) begin
      chk({phase, " model code0"}, int'(dacCode0), expCode(0));
      chk({phase, " model code1"}, int'(dacCode1), expCode(1));
      chk({phase, " model oe"},    int'(dacOe),    expOe());
      chk({phase, " model rd"},    int'(rdData),   expRd());
    end
  end

  task automatic wr(input bit nv, input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrNv = nv; wrSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input bit nv, input logic [1:0] sel, output int v);
    @(negedge clk);
    rdNv = nv; rdSel = sel;
    #1;
    v = int'(rdData);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    factoryRst_n = 1'b1;
    rst_n = 1'b1;

    // R2 / R3: load window
    phase = "R2";
    repeat (5) @(negedge clk);
    chk("R2 init code0", int'(dacCode0), 0);
    chk("R2 init oe", int'(dacOe), 3);
    phase = "R3";
    wr(1'b0, 2'd0, 8'h99);
    wr(1'b1, 2'd1, 8'h44);
    rd(1'b0, 2'd0, v);
    chk("R3 read during init", v, 0);
    repeat (INIT) @(negedge clk);

    // R1: factory state, and blocked writes left nothing
    phase = "R1";
    rd(1'b1, 2'd0, v); chk("R1 nv dac0", v, 0);
    rd(1'b1, 2'd1, v); chk("R1 nv dac1 / R3 blocked", v, 0);
    rd(1'b1, 2'd2, v); chk("R1 nv ctrl", v, 0);
    rd(1'b0, 2'd0, v); chk("R3 vol dac0 blocked", v, 0);

    // R4: working writes show, persistent writes do not
    phase = "R4";
    wr(1'b0, 2'd0, 8'hA5);
    chk("R4 code0", int'(dacCode0), 8'hA5);
    wr(1'b0, 2'd1, 8'h3C);
    chk("R4 code1", int'(dacCode1), 8'h3C);
    wr(1'b1, 2'd0, 8'h81);
    chk("R4 nv write no output", int'(dacCode0), 8'hA5);
    rd(1'b1, 2'd0, v); chk("R4 nv readback", v, 8'h81);

    // R5 / R6 / R9: soft mute
    phase = "R5";
    wr(1'b0, 2'd2, 8'hF1);
    rd(1'b0, 2'd2, v); chk("R5 ctrl upper bits zero", v, 8'h01);
    phase = "R6";
    chk("R6 muted code0", int'(dacCode0), 0);
    chk("R6 muted oe", int'(dacOe), 3);
    chk("R6 other channel live", int'(dacCode1), 8'h3C);
    rd(1'b0, 2'd0, v); chk("R6 reg kept", v, 8'hA5);
    phase = "R9";
    wr(1'b0, 2'd0, 8'h5A);
    chk("R9 write while muted hidden", int'(dacCode0), 0);
    wr(1'b0, 2'd2, 8'h00);
    chk("R9 unmute shows new", int'(dacCode0), 8'h5A);

    // R7 / R9: power-down
    phase = "R7";
    wr(1'b0, 2'd2, 8'h08);
    chk("R7 pd oe", int'(dacOe), 2'b01);
    chk("R7 pd code1", int'(dacCode1), 0);
    phase = "R9";
    wr(1'b0, 2'd1, 8'h77);
    chk("R9 pd kept", int'(dacOe), 2'b01);
    wr(1'b0, 2'd2, 8'h00);
    chk("R9 pd exit shows new", int'(dacCode1), 8'h77);

    // R8: mute pin latency and priority
    phase = "R8";
    @(negedge clk);
    muteIn = 1'b1;
    @(posedge clk); #1;
    chk("R8 one edge not yet", int'(dacCode0), 8'h5A);
    @(posedge clk); #1;
    chk("R8 second edge code0", int'(dacCode0), 0);
    chk("R8 second edge code1", int'(dacCode1), 0);
    wr(1'b0, 2'd2, 8'h04);
    chk("R8 pd under pin", int'(dacOe), 2'b10);
    wr(1'b0, 2'd2, 8'h00);
    @(negedge clk);
    muteIn = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 pin release", int'(dacCode1), 8'h77);

    // R10: unused select and soft reset persistence
    phase = "R10";
    wr(1'b0, 2'd3, 8'hEE);
    wr(1'b1, 2'd3, 8'hEE);
    rd(1'b0, 2'd3, v); chk("R10 unused read", v, 0);
    chk("R10 unused write no effect", int'(dacCode0), 8'h5A);
    wr(1'b1, 2'd1, 8'hC3);
    wr(1'b1, 2'd2, 8'h02);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    phase = "R2";
    repeat (3) @(negedge clk);
    chk("R2 reload window muted", int'(dacCode0), 0);
    repeat (INIT) @(negedge clk);
    phase = "R10";
    chk("R10 code0 from nv", int'(dacCode0), 8'h81);
    chk("R10 ctrl from nv mutes ch1", int'(dacCode1), 0);
    rd(1'b0, 2'd1, v); chk("R10 vol dac1 loaded", v, 8'hC3);
    rd(1'b0, 2'd2, v); chk("R10 vol ctrl loaded", v, 8'h02);
    rd(1'b1, 2'd0, v); chk("R10 nv survives", v, 8'h81);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule